// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills every word of a time-slot connection memory with one value in a single sweep that the hardware runs by itself, so software does not have to write each word. Software places a 5-bit fill pattern in bits 9:5 of a mode word and raises a level-sensitive arm bit. It then sets an enable bit. While both are high and no sweep is running, the block walks the whole memory, one word per clock from address 0 upward. Each word receives the pattern in its upper control field (bits 15:11) and zeros in its lower routing field (bits 10:0).

When the last word has been written, the block clears the enable bit itself. This stops the sweep from repeating. While a sweep runs, a busy flag is high and host writes to the memory are dropped. Host reads stay open at all times with a one-cycle latency.

The connection memory is modelled inside the block as a synchronous RAM with one write port and one registered read port.

Top module: `cmemBlockFill`

## Requirements
- R1: The fill pattern is taken from bits 9:5 of `modeWord` and written into bits 15:11 of every memory word. The other bits of `modeWord` have no effect.
- R2: Every memory word has bits 10:0 equal to zero after a sweep, whatever they held before.
- R3: A sweep starts only when `armBit` and `enBit` are both high while idle. `busy` rises on the clock edge after the one at which both are first seen high.
- R4: While `armBit` is low, a high `enBit` writes nothing, keeps `busy` low and stays high until software changes it.
- R5: A sweep keeps `busy` high for exactly 512 clock cycles. `enBit` falls on the same edge on which `busy` falls, and no new sweep starts afterwards.
- R6: A host write issued while `busy` is high is refused and leaves the memory unchanged.
- R7: After reset, `busy` and `enBit` are 0. While idle, a host write stores data that a read returns one clock later on `hostRdata`.
- R8: The pattern is captured when the sweep starts. Changing `modeWord` during a sweep does not change the words being written.
- R9: Lowering `armBit` during a sweep does not abort it.
- R10: A full sweep completes within two frame periods of `FRAME_CLKS` clocks each.
- R11: A write on `enWrite` sets `enBit` to `enWriteVal` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 16 | Mode word; bits 9:5 hold the fill pattern |
| armBit | input | 1 | Control-register arm bit for block fill |
| enWrite | input | 1 | Host write strobe for the enable bit |
| enWriteVal | input | 1 | Value written to the enable bit |
| enBit | output | 1 | Enable bit; cleared by the block when a sweep ends |
| busy | output | 1 | High while a sweep is in progress |
| hostWe | input | 1 | Host memory write strobe |
| hostAddr | input | 9 | Host memory address for reads and writes |
| hostWdata | input | 16 | Host memory write data |
| hostRdata | output | 16 | Registered read data for `hostAddr` |

## Verification
The first sweep starts from a memory that holds host data with non-zero low bits. It is also triggered in enable-then-arm order, and this separates a proper zero fill and the arm gate from a design that only overwrites the upper field or starts on enable alone. During that sweep the mode word is changed, arm is dropped and a host write is aimed at an address already swept. These stimuli separate pattern capture, run-to-completion and write refusal from a live, abortable or unguarded sweep. The second sweep uses a different pattern, arm-then-enable order and a mode word with all non-pattern bits set. This exposes wrong field extraction, and the exact busy length and the self-clear of enable are measured on both sweeps.

// File: rtl/cmemFillPkg.sv
`timescale 1ns/1ps
package cmemFillPkg;

  // Strobes issued by the sequencer to the fill datapath
  typedef struct packed {
    logic loadStart;   // capture pattern, rewind address
    logic incAddr;     // advance sweep address
    logic sweepWrite;  // sweep owns the memory write port
  } fillStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } fillState_t;

endpackage

// File: rtl/cmemRam.sv
`timescale 1ns/1ps
module cmemRam #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/cmemFillCtrl.sv
`timescale 1ns/1ps
module cmemFillCtrl
  import cmemFillPkg::*;
#(
  parameter int DEPTH      = 512,
  parameter int FRAME_CLKS = 512
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         armBit,
  input  logic         enWrite,
  input  logic         enWriteVal,
  input  logic         lastAddr,
  output logic         enBit,
  output logic         busy,
  output fillStrobes_t strobes
);
  localparam int SWEEP_LIMIT = 2 * FRAME_CLKS;

  fillState_t state, nextState;
  logic       doneClr;

  always_comb begin
    strobes   = '0;
    doneClr   = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (armBit && enBit) begin
          strobes.loadStart = 1'b1;
          nextState         = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        strobes.sweepWrite = 1'b1;
        if (lastAddr) begin
          doneClr   = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strobes.incAddr = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // Host write to the enable bit takes priority over the self-clear
  always_ff @(posedge clk) begin
    if (!rstN)        enBit <= 1'b0;
    else if (enWrite) enBit <= enWriteVal;
    else if (doneClr) enBit <= 1'b0;
  end

  assign busy = (state == ST_SWEEP);

  // ---------------- checks ----------------
  int unsigned busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= 0;
    else                busyCnt <= busyCnt + 1;
  end

  // R3: a sweep begins only after arm and enable were both high
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(armBit && enBit));

  // R4: enable alone with arm low never starts a sweep
  a_r4_no_start_unarmed: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !armBit) |=> !busy);

  // R5: enable is cleared when the sweep ends, absent a host write
  a_r5_en_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(enWrite)) |-> !enBit);

  // R5: busy lasts exactly DEPTH cycles
  a_r5_sweep_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyCnt) == DEPTH - 1));

  // R10: sweep fits inside two frame periods
  a_r10_two_frames: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < SWEEP_LIMIT));

endmodule

// File: rtl/cmemFillPath.sv
`timescale 1ns/1ps
module cmemFillPath
  import cmemFillPkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int MODE_W      = 16,
  parameter int PAT_W       = 5,
  parameter int PAT_SRC_LSB = 5,
  parameter int PAT_DST_LSB = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobes_t      strobes,
  input  logic              busy,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              lastAddr,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [MODE_W-1:0] SRC_MASK  = MODE_W'(((1 << PAT_W) - 1) << PAT_SRC_LSB);

  logic [PAT_W-1:0]  patReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] fillWord;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              unusedModeBits;

  assign unusedModeBits = ^(modeWord & ~SRC_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patReg  <= '0;
      addrReg <= '0;
    end else if (strobes.loadStart) begin
      patReg  <= modeWord[PAT_SRC_LSB +: PAT_W];
      addrReg <= '0;
    end else if (strobes.incAddr) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  assign lastAddr = (addrReg == LAST_ADDR);
  assign fillWord = DATA_W'(patReg) << PAT_DST_LSB;

  // Sweep owns the write port; host writes are dropped while busy
  always_comb begin
    if (strobes.sweepWrite) begin
      memWe    = 1'b1;
      memAddr  = addrReg;
      memWdata = fillWord;
    end else begin
      memWe    = hostWe && !busy;
      memAddr  = hostAddr;
      memWdata = hostWdata;
    end
  end

  cmemRam #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRam (
    .clk    (clk),
    .we     (memWe),
    .wrAddr (memAddr),
    .wrData (memWdata),
    .rdAddr (hostAddr),
    .rdData (hostRdata)
  );

  // ---------------- checks ----------------
  // R1: upper field of every swept word carries the captured pattern
  a_r1_fill_field: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memWe) |-> (memWdata[PAT_DST_LSB +: PAT_W] == patReg));

  // R2: lower routing field is zero in every swept word
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memWe) |-> (memWdata[PAT_DST_LSB-1:0] == '0));

  // R8: pattern held steady through the sweep
  a_r8_pattern_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(patReg));

  // R5: the sweep address steps by one each cycle
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (addrReg == $past(addrReg) + 1'b1));

endmodule

// File: rtl/cmemBlockFill.sv
`timescale 1ns/1ps
module cmemBlockFill
  import cmemFillPkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int MODE_W      = 16,
  parameter int PAT_W       = 5,
  parameter int PAT_SRC_LSB = 5,
  parameter int PAT_DST_LSB = 11,
  parameter int FRAME_CLKS  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              armBit,
  input  logic              enWrite,
  input  logic              enWriteVal,
  output logic              enBit,
  output logic              busy,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  fillStrobes_t strobes;
  logic         lastAddr;

  cmemFillCtrl #(.DEPTH(DEPTH), .FRAME_CLKS(FRAME_CLKS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .armBit     (armBit),
    .enWrite    (enWrite),
    .enWriteVal (enWriteVal),
    .lastAddr   (lastAddr),
    .enBit      (enBit),
    .busy       (busy),
    .strobes    (strobes)
  );

  cmemFillPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .PAT_W(PAT_W),
    .PAT_SRC_LSB(PAT_SRC_LSB), .PAT_DST_LSB(PAT_DST_LSB)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busy      (busy),
    .modeWord  (modeWord),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .lastAddr  (lastAddr),
    .hostRdata (hostRdata)
  );

endmodule

// File: tb/cmemBlockFill_test.sv
`timescale 1ns/1ps
module cmemBlockFill_test;
  localparam int DEPTH      = 512;
  localparam int FRAME_CLKS = 512;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] modeWord;
  logic        armBit, enWrite, enWriteVal, enBit, busy, hostWe;
  logic [8:0]  hostAddr;
  logic [15:0] hostWdata, hostRdata;

  always #2.5 clk = ~clk;

  cmemBlockFill uut (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .armBit(armBit),
    .enWrite(enWrite), .enWriteVal(enWriteVal), .enBit(enBit), .busy(busy),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [8:0]  addr;
    logic [15:0] exp;
    string       tag;
    int          issue;
  } rdItem_t;

  rdItem_t sbq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data one clock after the address was driven
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].issue < cyc) begin
      rdItem_t it;
      it = sbq.pop_front();
      checks++;
      if (hostRdata !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%0h expected=%0h",
                 it.tag, it.addr, hostRdata, it.exp);
      end
    end
  end

  // Driver: issue a read and push the expected word
  task automatic rdExpect(logic [8:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    hostAddr = a;
    sbq.push_back('{a, e, tag, cyc});
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic hostWrite(logic [8:0] a, logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic writeEnable(logic v);
    @(negedge clk);
    enWrite = 1'b1; enWriteVal = v;
    @(negedge clk);
    enWrite = 1'b0;
  endtask

  function automatic logic [15:0] fillOf(logic [4:0] p);
    return {p, 11'b0};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    int stuck;
    rstN = 1'b0; modeWord = '0; armBit = 1'b0; enWrite = 1'b0; enWriteVal = 1'b0;
    hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset enBit", enBit, 0);

    // R7: idle host writes land and read back
    hostWrite(9'd3, 16'h1234);
    hostWrite(9'd5, 16'h07FF);
    hostWrite(9'd511, 16'hBEEF);
    rdExpect(9'd3, 16'h1234, "R7 idle write 3");
    rdExpect(9'd511, 16'hBEEF, "R7 idle write 511");
    drain();

    // R4 / R11: enable with arm low does nothing
    modeWord = 16'h0015 << 5;
    writeEnable(1'b1);
    stuck = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy) stuck++;
    end
    chk("R4 no sweep while unarmed", stuck, 0);
    chk("R11 R4 enBit held", enBit, 1);
    rdExpect(9'd3, 16'h1234, "R4 memory untouched");
    drain();

    // First sweep: arm raised after enable (R3)
    @(negedge clk);
    armBit = 1'b1;
    @(negedge clk);
    chk("R3 busy after arm with enable", busy, 1);
    n = 1;
    forever begin
      @(negedge clk);
      if (hostWe) hostWe = 1'b0;
      if (!busy) break;
      n++;
      if (n == 10) begin
        modeWord = 16'hFFFF;   // R8 pattern change mid-sweep
        armBit   = 1'b0;       // R9 arm dropped mid-sweep
      end
      if (n == 200) begin
        hostWe = 1'b1; hostAddr = 9'd5; hostWdata = 16'hFFFF; // R6
      end
    end
    chk("R5 R9 busy length sweep 1", n, DEPTH);
    chk("R10 within two frames", (n <= 2 * FRAME_CLKS), 1);
    chk("R5 enBit self-cleared", enBit, 0);
    repeat (5) @(negedge clk);
    chk("R5 no restart", busy, 0);

    rdExpect(9'd0,   fillOf(5'h15), "R1 word 0");
    rdExpect(9'd3,   fillOf(5'h15), "R2 low field cleared word 3");
    rdExpect(9'd5,   fillOf(5'h15), "R6 refused host write word 5");
    rdExpect(9'd300, fillOf(5'h15), "R8 pattern captured word 300");
    rdExpect(9'd511, fillOf(5'h15), "R1 last word");
    for (int a = 0; a < DEPTH; a += 17) rdExpect(9'(a), fillOf(5'h15), "R1 R2 scan sweep 1");
    drain();

    // Second sweep: arm first, then enable; noisy mode word (R1)
    modeWord = 16'hFC1F | (16'h000B << 5);
    @(negedge clk);
    armBit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 armed without enable stays idle", busy, 0);
    @(negedge clk);
    enWrite = 1'b1; enWriteVal = 1'b1;
    @(negedge clk);
    enWrite = 1'b0;
    chk("R11 enBit set", enBit, 1);
    chk("R3 one cycle before start", busy, 0);
    @(negedge clk);
    chk("R3 start after enable", busy, 1);
    n = 1;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    chk("R5 busy length sweep 2", n, DEPTH);
    chk("R5 enBit cleared sweep 2", enBit, 0);
    armBit = 1'b0;
    for (int a = 0; a < DEPTH; a += 13) rdExpect(9'(a), fillOf(5'h0B), "R1 R2 scan sweep 2");
    rdExpect(9'd511, fillOf(5'h0B), "R1 sweep 2 last");
    drain();

    // R7: host writes work again once idle
    hostWrite(9'd42, 16'hA5A5);
    rdExpect(9'd42, 16'hA5A5, "R7 write after sweep");
    drain();

    summary();
    $finish;
  end

endmodule